// File: doc/BRIEF.md
# Spare-Word Address Remapper with Deferred Spare Writes

This block sits between a system-side request stream and an on-chip SRAM built from a main array and a small spare array. A bank of repair entries records faulty main-array addresses. When an access hits one of them, the data is redirected to a spare word. The spare array is direct-mapped. The low `IDX_W` address bits choose both the repair entry and the spare word. Each entry stores the remaining upper bits as a tag, plus an enable bit. As a result, at most one faulty address per low-bit index can be repaired.

Reads go to the main word and to the indexed spare word in the same cycle. The fault lookup is registered alongside them, and one cycle later an output multiplexer returns one of three values: the main data, the spare data, or the contents of the pending write buffer.

Writes always update the main array at once. When a write hits a repair entry, its address and data are parked in a one-entry write buffer. The parked word is written into the spare array during the next write request. That write may park new data in the same cycle. Because of this, the tag comparison never sits between the request pins and either array.

The request side is a valid/ready input. `req_ready` is held high, so the block never applies back-pressure, and every cycle with `req_valid` high is an accepted request. The read response is a plain valid strobe with no ready. The consumer must take `rsp_data` in the cycle `rsp_valid` is high. Repair entries are loaded through a side port that only acts in cycles with no request.

Top module: `spare_remap_wb`

## Requirements
- R1: An accepted read (`req_we`=0) drives `m_en`=1, `m_we`=0, `m_addr`=`req_addr` and, in the same cycle, `s_en`=1, `s_we`=0, `s_addr`=`req_addr[IDX_W-1:0]`.
- R2: An accepted write drives `m_en`=1, `m_we`=1, `m_addr`=`req_addr`, `m_wdata`=`req_wdata` in the same cycle, whether or not the address is repaired.
- R3: A write whose address hits an enabled repair entry does not write the spare array in its own cycle. Its data is written (`s_we`=1, `s_addr`=its low `IDX_W` bits, `s_wdata`=its data) during the next accepted write. `s_we` is never high outside an accepted write.
- R4: A write whose address hits no enabled repair entry parks nothing. The next write then produces no spare write. If a word was already parked, that word is still committed in this cycle.
- R5: `rsp_valid` is high exactly in the cycle after an accepted read and low otherwise. `rsp_data` in that cycle is the last value written to the address, provided the address is repaired or fault-free.
- R6: A read of an address whose data is still parked in the write buffer returns the parked data, including a read in the cycle right after the write.
- R7: A repair entry loaded with `ld_on`=0 never matches. Reads of that address return main-array data.
- R8: A load (`ld_en`=1) in a cycle with `req_valid`=1 is ignored. The entry keeps its previous state.
- R9: During reset, `rsp_valid`, `m_en` and `s_en` are low. After reset, all repair entries are disabled and the buffer is empty. Cycles without a request drive neither array.
- R10: `req_ready` is always high. No request is ever refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | DATA_W | Read data |
| ld_en | input | 1 | Load one repair entry |
| ld_addr | input | ADDR_W | Faulty address to record; low bits select the entry |
| ld_on | input | 1 | Enable bit written with the entry |
| m_en | output | 1 | Main array enable |
| m_we | output | 1 | Main array write enable |
| m_addr | output | ADDR_W | Main array address |
| m_wdata | output | DATA_W | Main array write data |
| m_rdata | input | DATA_W | Main array read data, one cycle after the read |
| s_en | output | 1 | Spare array enable |
| s_we | output | 1 | Spare array write enable |
| s_addr | output | IDX_W | Spare array word select |
| s_wdata | output | DATA_W | Spare array write data |
| s_rdata | input | DATA_W | Spare array read data, one cycle after the read |

## Verification
The array strobes, addresses and the committed spare word are combinational in the request cycle. The bench checks them shortly after driving each request, well before the next clock edge. Read data and `rsp_valid` are due one edge after the request. The bench keeps each read's expected word pending and checks it at the following falling edge, while the next request is being driven, so back-to-back write-then-read pairs are covered. Loads take effect at the edge. Their effect, or the lack of it, is observed through a later read.

// File: rtl/remap_pkg.sv
package remap_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } remap_op_e;

  function automatic remap_op_e decode_op(input logic valid, input logic we);
    if (!valid)  return OP_IDLE;
    else if (we) return OP_WRITE;
    else         return OP_READ;
  endfunction
endpackage

// File: rtl/remap_tagbank.sv
module remap_tagbank #(
  parameter int ADDR_W = 8,
  parameter int NSPARE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_fire,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              ld_on,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              hit
);
  localparam int IDX_W = $clog2(NSPARE);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [NSPARE-1:0]           ent_on;
  logic [NSPARE-1:0][TAG_W-1:0] ent_tag;

  for (genvar g = 0; g < NSPARE; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_on[g]  <= 1'b0;
        ent_tag[g] <= '0;
      end else if (ld_fire && ld_addr[IDX_W-1:0] == IDX_W'(g)) begin
        ent_on[g]  <= ld_on;
        ent_tag[g] <= ld_addr[ADDR_W-1:IDX_W];
      end
    end
  end

  logic [IDX_W-1:0] look_idx;
  assign look_idx = look_addr[IDX_W-1:0];
  assign hit = ent_on[look_idx] && (ent_tag[look_idx] == look_addr[ADDR_W-1:IDX_W]);
endmodule

// File: rtl/remap_wbuf.sv
module remap_wbuf #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic              wr_hit,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pend,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [DATA_W-1:0] pend_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
    end else if (wr_fire) begin
      pend <= wr_hit;
      if (wr_hit) begin
        pend_addr <= wr_addr;
        pend_data <= wr_data;
      end
    end
  end
endmodule

// File: rtl/spare_remap_wb.sv
module spare_remap_wb
  import remap_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int NSPARE = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_we,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  output logic                       rsp_valid,
  output logic [DATA_W-1:0]          rsp_data,
  input  logic                       ld_en,
  input  logic [ADDR_W-1:0]          ld_addr,
  input  logic                       ld_on,
  output logic                       m_en,
  output logic                       m_we,
  output logic [ADDR_W-1:0]          m_addr,
  output logic [DATA_W-1:0]          m_wdata,
  input  logic [DATA_W-1:0]          m_rdata,
  output logic                       s_en,
  output logic                       s_we,
  output logic [$clog2(NSPARE)-1:0]  s_addr,
  output logic [DATA_W-1:0]          s_wdata,
  input  logic [DATA_W-1:0]          s_rdata
);
  localparam int IDX_W = $clog2(NSPARE);

  remap_op_e op;
  logic rd, wr, hit, ld_fire;
  logic pend;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;
  logic hit_q, bufhit_q;

  assign op        = decode_op(req_valid, req_we);
  assign rd        = (op == OP_READ);
  assign wr        = (op == OP_WRITE);
  assign req_ready = 1'b1;
  assign ld_fire   = ld_en && !req_valid;

  remap_tagbank #(.ADDR_W(ADDR_W), .NSPARE(NSPARE)) u_tags (
    .clk(clk), .rst_n(rst_n), .ld_fire(ld_fire), .ld_addr(ld_addr),
    .ld_on(ld_on), .look_addr(req_addr), .hit(hit)
  );

  remap_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr), .wr_hit(hit),
    .wr_addr(req_addr), .wr_data(req_wdata),
    .pend(pend), .pend_addr(pend_addr), .pend_data(pend_data)
  );

  // input side: main array straight through, spare address one mux
  assign m_en    = rd || wr;
  assign m_we    = wr;
  assign m_addr  = req_addr;
  assign m_wdata = req_wdata;
  assign s_en    = rd || (wr && pend);
  assign s_we    = wr && pend;
  assign s_addr  = wr ? pend_addr[IDX_W-1:0] : req_addr[IDX_W-1:0];
  assign s_wdata = pend_data;

  // lookup registered beside the array access
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      hit_q     <= 1'b0;
      bufhit_q  <= 1'b0;
    end else begin
      rsp_valid <= rd;
      hit_q     <= rd && hit;
      bufhit_q  <= rd && pend && (pend_addr == req_addr);
    end
  end

  // output side: one mux
  assign rsp_data = !hit_q ? m_rdata : (bufhit_q ? pend_data : s_rdata);
endmodule

// File: rtl/remap_chk.sv
module remap_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_we,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              m_en,
  input logic              m_we,
  input logic [ADDR_W-1:0] m_addr,
  input logic [DATA_W-1:0] m_wdata,
  input logic              s_en,
  input logic              s_we,
  input logic [IDX_W-1:0]  s_addr
);
  AST_READ_PARALLEL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |-> (m_en && s_en && !m_we && !s_we && m_addr == req_addr && s_addr == req_addr[IDX_W-1:0])); // R1
  AST_WRITE_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we) |-> (m_en && m_we && m_addr == req_addr && m_wdata == req_wdata)); // R2
  AST_SPARE_WRITE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    s_we |-> (req_valid && req_we)); // R3
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |=> rsp_valid); // R5
  AST_RSP_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_we) |=> !rsp_valid); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!m_en && !s_en)); // R9
  AST_ALWAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_ready); // R10
endmodule

bind spare_remap_wb remap_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .m_en(m_en), .m_we(m_we), .m_addr(m_addr),
  .m_wdata(m_wdata), .s_en(s_en), .s_we(s_we), .s_addr(s_addr)
);

// File: tb/sim_spare_remap_wb.sv
module sim_spare_remap_wb;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NS = 4;
  localparam int IW = 2;
  localparam logic [DW-1:0] FLIP = 16'h5A5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, ld_en = 1'b0, ld_on = 1'b0;
  logic [AW-1:0] req_addr = '0, ld_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, m_en, m_we, s_en, s_we;
  logic [DW-1:0] rsp_data, m_wdata, s_wdata, m_rdata, s_rdata;
  logic [AW-1:0] m_addr;
  logic [IW-1:0] s_addr;

  always #2 clk = ~clk;

  spare_remap_wb #(.ADDR_W(AW), .DATA_W(DW), .NSPARE(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .ld_en(ld_en),
    .ld_addr(ld_addr), .ld_on(ld_on), .m_en(m_en), .m_we(m_we),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata), .s_en(s_en),
    .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata)
  );

  // faulty main-array words store corrupted data
  function automatic logic is_faulty(input logic [AW-1:0] a);
    return (a == 8'h10) || (a == 8'h25) || (a == 8'hA6) || (a == 8'h3B);
  endfunction

  logic [DW-1:0] main_mem [256];
  logic [DW-1:0] spare_mem [NS];
  logic [DW-1:0] m_rq, s_rq;
  assign m_rdata = m_rq;
  assign s_rdata = s_rq;
  always @(posedge clk) begin
    if (m_en) begin
      if (m_we) main_mem[m_addr] <= is_faulty(m_addr) ? (m_wdata ^ FLIP) : m_wdata;
      else      m_rq <= main_mem[m_addr];
    end
    if (s_en) begin
      if (s_we) spare_mem[s_addr] <= s_wdata;
      else      s_rq <= spare_mem[s_addr];
    end
  end

  // bench reference state
  logic [DW-1:0] golden [256];
  logic          rep_on  [NS];
  logic [AW-3:0] rep_tag [NS];
  logic          wbv;
  logic [AW-1:0] wba;
  logic [DW-1:0] wbd;
  logic          pend_rd;
  logic [DW-1:0] pend_exp;
  logic [AW-1:0] pend_a;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  function automatic logic repaired(input logic [AW-1:0] a);
    return rep_on[a[1:0]] && rep_tag[a[1:0]] == a[7:2];
  endfunction

  function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
    if (repaired(a))     return golden[a];
    else if (is_faulty(a)) return golden[a] ^ FLIP;
    else                 return golden[a];
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called just after a falling edge; leaves at the next falling edge
  task automatic step(input logic v, input logic we, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic le, input logic [AW-1:0] la,
                      input logic lo);
    if (pend_rd) begin
      chk(rsp_valid === 1'b1, "R5 rsp_valid after read", 32'(rsp_valid), 32'd1);
      chk(rsp_data === pend_exp, (wbv && wba == pend_a) ? "R6 parked data" : "R5 read data",
          32'(rsp_data), 32'(pend_exp));
    end else begin
      chk(rsp_valid === 1'b0, "R5 no response", 32'(rsp_valid), 32'd0);
    end
    req_valid = v; req_we = we; req_addr = a; req_wdata = d;
    ld_en = le; ld_addr = la; ld_on = lo;
    #1;
    chk(req_ready === 1'b1, "R10 ready", 32'(req_ready), 32'd1);
    if (v && !we) begin
      chk(m_en && !m_we && s_en && !s_we && m_addr == a && s_addr == a[1:0],
          "R1 parallel read", {m_en, m_we, s_en, s_we, 4'h0, m_addr, 6'h0, s_addr},
          {8'hA0, a, 6'h0, a[1:0]});
    end else if (v && we) begin
      chk(m_en && m_we && m_addr == a && m_wdata == d, "R2 main write",
          {8'h0, m_addr, m_wdata}, {8'h0, a, d});
      chk(s_we === wbv, wbv ? "R3 commit on next write" : "R4 no spare write", 32'(s_we), 32'(wbv));
      if (wbv)
        chk(s_addr == wba[1:0] && s_wdata == wbd, "R3 committed word",
            {14'h0, s_addr, s_wdata}, {14'h0, wba[1:0], wbd});
    end else begin
      chk(!m_en && !s_en, "R9 idle quiet", {m_en, s_en}, 32'd0);
    end
    // update reference after the edge
    pend_rd = v && !we;
    pend_a = a;
    if (v && !we) pend_exp = (repaired(a) && wbv && wba == a) ? wbd : exp_read(a);
    if (v && we) begin
      golden[a] = d;
      wbv = repaired(a);
      if (repaired(a)) begin wba = a; wbd = d; end
    end
    if (le && !v) begin rep_on[la[1:0]] = lo; rep_tag[la[1:0]] = la[7:2]; end
    @(negedge clk);
  endtask

  logic [AW-1:0] flist [4];

  initial begin
    for (int i = 0; i < 256; i++) begin main_mem[i] = '0; golden[i] = '0; end
    for (int i = 0; i < NS; i++) begin spare_mem[i] = '0; rep_on[i] = 1'b0; rep_tag[i] = '0; end
    m_rq = '0; s_rq = '0;
    wbv = 1'b0; wba = '0; wbd = '0; pend_rd = 1'b0; pend_exp = '0; pend_a = '0;
    flist[0] = 8'h10; flist[1] = 8'h25; flist[2] = 8'hA6; flist[3] = 8'h3B;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(rsp_valid === 1'b0 && m_en === 1'b0 && s_en === 1'b0, "R9 reset outputs",
        {rsp_valid, m_en, s_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: entries disabled after reset -> faulty word reads corrupted main data
    step(1, 1, 8'h25, 16'h1111, 0, 0, 0);
    step(1, 0, 8'h25, 0, 0, 0, 0);
    step(1, 1, 8'h25, 16'h0000, 0, 0, 0);  // restore golden 0
    // load three entries, idle cycles
    step(0, 0, 0, 0, 1, 8'h25, 1);
    step(0, 0, 0, 0, 1, 8'hA6, 1);
    step(0, 0, 0, 0, 1, 8'h3B, 1);
    // R7: entry loaded disabled
    step(0, 0, 0, 0, 1, 8'h10, 0);
    step(1, 1, 8'h10, 16'hBEEF, 0, 0, 0);
    step(1, 0, 8'h10, 0, 0, 0, 0);          // R7 expect corrupted main data
    // R8: load attempt during a request is ignored
    step(1, 0, 8'h10, 0, 1, 8'h10, 1);
    step(1, 0, 8'h10, 0, 0, 0, 0);          // R8 still main data
    // proper load, then write/read patterns
    step(0, 0, 0, 0, 1, 8'h10, 1);
    step(1, 1, 8'h10, 16'hC0DE, 0, 0, 0);   // R3 parked
    step(1, 0, 8'h10, 0, 0, 0, 0);          // R6 read right after write
    step(1, 1, 8'h44, 16'h4444, 0, 0, 0);   // R3 commit, R4 nothing parked
    step(1, 0, 8'h10, 0, 0, 0, 0);          // from spare array
    step(1, 1, 8'h55, 16'h5555, 0, 0, 0);   // R4 no spare write
    step(1, 1, 8'hA6, 16'hA6A6, 0, 0, 0);
    step(1, 1, 8'h3B, 16'h3B3B, 0, 0, 0);   // commit A6, park 3B
    step(1, 0, 8'hA6, 0, 0, 0, 0);
    step(1, 0, 8'h3B, 0, 0, 0, 0);          // R6
    step(0, 0, 0, 0, 0, 0, 0);
    // constrained random traffic
    begin
      int unsigned sd;
      sd = $urandom(32'd2024);
      for (int n = 0; n < 1500; n++) begin
        logic [AW-1:0] a;
        logic w;
        int unsigned r;
        r = $urandom % 8;
        a = (r < 4) ? flist[$urandom % 4] : AW'($urandom % 256);
        w = ($urandom % 2) == 1;
        if (r == 7) step(0, 0, 0, 0, 0, 0, 0);
        else        step(1, w, a, DW'($urandom), 0, 0, 0);
      end
    end
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule